// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-bus slave that runs Clause 22 management frames towards Ethernet PHYs on the MDC and MDIO pins. It exposes two 32-bit words: a command/status word at byte offset 0 and a write-data word at byte offset 4. Software writes a command word carrying a PHY address, a register address and one of two start bits. The block then generates MDC from the system clock, shifts the whole frame out and, for a read, samples the PHY's answer back in.

Each start bit doubles as a busy flag and is cleared by the hardware when its frame ends. The 16-bit value returned by a read lands in the low half of the command word itself, so a single poll of offset 0 shows both completion and data. A PHY that does not answer leaves the line at its pull-up level, so the read still completes and returns all ones. Commands written while a frame is running are dropped.

Top module: `mdm_mgmt_master`

## Requirements
- R1: After reset, both words read as zero, MDC is low and MDIO is not driven. MDC stays low and MDIO stays released whenever no frame is busy.
- R2: A write frame sends these 64 bits MSB first, in this order: 32 ones, start code 01, opcode 01, the PHY address (5 bits), the register address (5 bits), turnaround 10, and the low 16 bits of the write-data word.
- R3: A read frame sends 32 ones, start code 01, opcode 10 and both 5-bit addresses. It then releases MDIO (`mdio_oe` low) for the two turnaround bits and the 16 data bits.
- R4: The block samples a read on the rising edges of MDC over data bits 48..63, MSB first. When the frame ends, command bit 26 clears and bits 15:0 hold the value. Bits 15:0 keep their value while a frame is busy.
- R5: Writing the command word with bit 27 set (bit 26 clear) starts a write frame. Bit 27 reads as 1 until the last bit has been shifted out, then clears.
- R6: A read from an address whose PHY does not drive the line returns 0xFFFF in bits 15:0.
- R7: A command-word write that arrives while bit 26 or bit 27 is set has no effect. The address fields (bits 25:21 register, 20:16 PHY), the result and the frame count do not change.
- R8: If bits 26 and 27 are both set in one command write, a read frame runs, and only bit 26 is set while it runs.
- R9: MDIO output changes only on a falling MDC edge, so it is stable across every rising edge.
- R10: Every MDC half-period lasts exactly HALF_DIV system clock cycles.
- R11: The write-data word stores only its low 16 bits; bits 31:16 read as zero.
- R12: Every PHY address 0..31 can be written and read, and every read completes whether or not a PHY answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | Write enable qualifying bus_sel |
| bus_addr | input | 3 | Byte offset: 0 command word, 4 write-data word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low = released) |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The assertions assume single-cycle bus accesses at word-aligned offsets. They also assume `mdio_i` settles before each rising MDC edge and holds through it. The bench's PHY model keeps to this by changing its drive only one half system cycle after MDC falls, and by acting as the pull-up when it stays silent. All register accesses are made away from the clock edge, and every command is spaced by polling for idle, except in the scenario that deliberately overlaps a command with a running frame.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam int CMD_WR_BIT = 27;
  localparam int CMD_RD_BIT = 26;
  localparam int REG_LSB    = 21;
  localparam int PHY_LSB    = 16;

  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  typedef logic [FRAME_BITS-1:0] frame_t;
  typedef logic [ADDR_W-1:0]     maddr_t;
  typedef logic [DATA_W-1:0]     mdata_t;

  // Serial image of one management frame, first bit in the MSB.
  function automatic frame_t build_frame(logic is_rd, maddr_t phy, maddr_t regad, mdata_t wd);
    logic [1:0] op;
    logic [1:0] ta;
    mdata_t     payload;
    op      = is_rd ? 2'b10 : 2'b01;
    ta      = is_rd ? 2'b11 : 2'b10;
    payload = is_rd ? '1 : wd;
    return {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad, ta, payload};
  endfunction

  // True when the master must not drive MDIO at this bit position.
  function automatic logic line_released(logic is_rd, logic [IDX_W-1:0] idx);
    return is_rd && (idx >= TA_IDX);
  endfunction

  function automatic logic [31:0] pack_cmd(logic wr_busy, logic rd_busy, maddr_t regad,
                                           maddr_t phy, mdata_t result);
    return {4'b0000, wr_busy, rd_busy, regad, phy, result};
  endfunction
endpackage

// File: rtl/mdm_clk_div.sv
module mdm_clk_div #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST  = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] HALFV = CW'(HALF_DIV);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = en && (cnt == LAST);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // Independent count of cycles spent high, checked on each falling edge.
  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !mdc) hi_cnt <= '0;
    else                hi_cnt <= hi_cnt + CW'(1);
  end

  p_mdc_high_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == HALFV));
endmodule

// File: rtl/mdm_frame_eng.sv
module mdm_frame_eng
  import mdm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_rd,
  input  maddr_t phy,
  input  maddr_t regad,
  input  mdata_t wdata,
  input  logic   rise_tick,
  input  logic   fall_tick,
  input  logic   mdio_i,
  output logic   running,
  output logic   mdio_o,
  output logic   mdio_oe,
  output logic   done,
  output mdata_t rx_data
);
  frame_t           shreg;
  frame_t           new_frame;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] nxt_idx;
  logic             is_rd;
  logic             last_bit;
  logic             sample_now;

  assign new_frame  = build_frame(start_rd, phy, regad, wdata);
  assign nxt_idx    = idx + IDX_W'(1);
  assign last_bit   = (idx == LAST_IDX);
  assign done       = running && fall_tick && last_bit;
  assign sample_now = running && rise_tick && is_rd && (idx >= DATA_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      running <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rx_data <= '0;
    end else if (start) begin
      shreg   <= new_frame;
      idx     <= '0;
      is_rd   <= start_rd;
      running <= 1'b1;
      mdio_o  <= new_frame[FRAME_BITS-1];
      mdio_oe <= 1'b1;
    end else if (running) begin
      if (sample_now) rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          running <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          idx     <= nxt_idx;
          shreg   <= shreg << 1;
          mdio_o  <= shreg[FRAME_BITS-2];
          mdio_oe <= !line_released(is_rd, nxt_idx);
        end
      end
    end
  end

  p_mdio_moves_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $past(fall_tick));

  p_released_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && is_rd && idx >= TA_IDX) |-> !mdio_oe);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !mdio_oe);
endmodule

// File: rtl/mdm_mgmt_master.sv
module mdm_mgmt_master
  import mdm_pkg::*;
#(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_DATA = 3'd4;

  mdata_t wdata_q;
  mdata_t result_q;
  maddr_t phy_q;
  maddr_t reg_q;
  logic   rd_busy;
  logic   wr_busy;

  logic   busy;
  logic   cmd_wr;
  logic   data_wr;
  logic   go_rd;
  logic   go_wr;
  logic   start;
  maddr_t cmd_phy;
  maddr_t cmd_reg;
  logic   running;
  logic   done;
  logic   rise_tick;
  logic   fall_tick;
  mdata_t rx_data;
  logic   unused_hi;

  assign busy    = rd_busy || wr_busy;
  assign cmd_wr  = bus_sel && bus_we && (bus_addr == OFS_CMD);
  assign data_wr = bus_sel && bus_we && (bus_addr == OFS_DATA);
  assign cmd_phy = bus_wdata[PHY_LSB +: ADDR_W];
  assign cmd_reg = bus_wdata[REG_LSB +: ADDR_W];
  assign go_rd   = cmd_wr && !busy && bus_wdata[CMD_RD_BIT];
  assign go_wr   = cmd_wr && !busy && bus_wdata[CMD_WR_BIT] && !bus_wdata[CMD_RD_BIT];
  assign start   = go_rd || go_wr;
  assign unused_hi = ^bus_wdata[31:28];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q  <= '0;
      result_q <= '0;
      phy_q    <= '0;
      reg_q    <= '0;
      rd_busy  <= 1'b0;
      wr_busy  <= 1'b0;
    end else begin
      if (data_wr) wdata_q <= bus_wdata[DATA_W-1:0];
      if (cmd_wr && !busy) begin
        phy_q   <= cmd_phy;
        reg_q   <= cmd_reg;
        rd_busy <= go_rd;
        wr_busy <= go_wr;
      end else if (done) begin
        if (rd_busy) result_q <= rx_data;
        rd_busy <= 1'b0;
        wr_busy <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CMD:  bus_rdata = pack_cmd(wr_busy, rd_busy, reg_q, phy_q, result_q);
      OFS_DATA: bus_rdata = {16'h0000, wdata_q};
      default:  bus_rdata = '0;
    endcase
  end

  mdm_clk_div #(.HALF_DIV(HALF_DIV)) clk_div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (running),
    .mdc       (mdc_o),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdm_frame_eng frame_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_rd  (go_rd),
    .phy       (cmd_phy),
    .regad     (cmd_reg),
    .wdata     (wdata_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .running   (running),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rx_data   (rx_data)
  );

  p_one_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_busy, wr_busy}));

  p_ignore_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> ($stable(phy_q) && $stable(reg_q)));

  p_result_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(result_q));

  p_mdc_low_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc_o);

  p_busy_tracks_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> busy);
endmodule

// File: tb/mdm_mgmt_master_tb_top.sv
module mdm_mgmt_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc_o, mdio_o, mdio_oe, mdio_i;
  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b1;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int rises = 0;
  int t1 = 0, t2 = 0;
  int bad9 = 0;
  logic [63:0] cap = '0;
  logic [63:0] oe_cap = '0;
  logic mdc_q = 1'b0;
  logic mdio_prev = 1'b1;
  logic [15:0] mem [32][32];

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  mdm_mgmt_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic [15:0] init_val(int p, int r);
    logic [4:0] pp = 5'(p);
    logic [4:0] rr = 5'(r);
    return {rr, pp, 1'b0, pp ^ rr};
  endfunction

  function automatic logic present(logic [4:0] p);
    return p[1:0] != 2'b11;
  endfunction

  function automatic logic [63:0] exp_frame(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] wd);
    logic [63:0] f = '0;
    for (int k = 0; k < 64; k++) begin
      logic b;
      if (k < 32)       b = 1'b1;
      else if (k == 32) b = 1'b0;
      else if (k == 33) b = 1'b1;
      else if (k == 34) b = rd;
      else if (k == 35) b = !rd;
      else if (k <= 40) b = p[40-k];
      else if (k <= 45) b = r[45-k];
      else if (k == 46) b = 1'b1;
      else if (k == 47) b = 1'b0;
      else              b = wd[63-k];
      f[63-k] = b;
    end
    return f;
  endfunction

  // PHY model: acts half a system cycle after each MDC edge.
  task automatic phy_fall();
    int k = rises;
    logic rd = cap[29] && !cap[28];
    logic [4:0] p = cap[27:23];
    logic [4:0] r = cap[22:18];
    if (k == 47 && rd && present(p)) begin
      phy_en = 1'b1; phy_bit = 1'b0;
    end else if (k >= 48 && k <= 63 && rd && present(p)) begin
      phy_bit = mem[p][r][63-k];
    end else if (k == 64) begin
      phy_en = 1'b0;
      if (!rd && present(p)) mem[p][r] = cap[15:0];
    end
  endtask

  always @(negedge clk) begin
    if (mdc_o && mdc_q && (mdio_o !== mdio_prev)) bad9++;
    if (mdc_o && !mdc_q) begin
      if (rises < 64) begin
        cap[63-rises]    = mdio_i;
        oe_cap[63-rises] = mdio_oe;
      end
      rises++;
      if (rises == 1) t1 = cyc;
      if (rises == 2) t2 = cyc;
    end
    if (!mdc_o && mdc_q) phy_fall();
    mdc_q = mdc_o;
    mdio_prev = mdio_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      bus_rd(3'd0, d);
      if (d[27:26] == 2'b00) break;
    end
  endtask

  function automatic logic [31:0] cmd(logic wr, logic rd, logic [4:0] p, logic [4:0] r);
    return {4'b0, wr, rd, r, p, 16'h0000};
  endfunction

  // Runs one frame and checks stream, busy flag and (for reads) the result.
  task automatic run_cmd(input logic rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] wd, input string req);
    logic [31:0] d;
    logic [63:0] ef;
    if (!rd) bus_wr(3'd4, {16'hC0DE, wd});
    rises = 0;
    bus_wr(3'd0, cmd(!rd, rd, p, r));
    bus_rd(3'd0, d);
    chk({req, " busy flag"}, {62'd0, d[27:26]}, rd ? 64'd1 : 64'd2);
    wait_idle();
    ef = exp_frame(rd, p, r, wd);
    chk({req, " frame length"}, 64'(rises), 64'd64);
    if (rd) begin
      chk({req, " R3 read header"}, {18'd0, cap[63:18]}, {18'd0, ef[63:18]});
      chk({req, " R3 released"}, {46'd0, oe_cap[17:0]}, 64'd0);
      bus_rd(3'd0, d);
      chk({req, " R4 result"}, {32'd0, d}, {32'd0, cmd(1'b0, 1'b0, p, r) |
          {16'd0, (present(p) ? mem[p][r] : 16'hFFFF)}});
    end else begin
      chk({req, " R2 write stream"}, cap, ef);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) mem[p][r] = init_val(p, r);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(3'd0, d); chk("R1 command word after reset", 64'(d), 64'd0);
    bus_rd(3'd4, d); chk("R1 data word after reset", 64'(d), 64'd0);
    chk("R1 mdc low", 64'(mdc_o), 64'd0);
    chk("R1 mdio released", 64'(mdio_oe), 64'd0);

    // R11 only low half of write-data word kept
    bus_wr(3'd4, 32'hABCD_1234);
    bus_rd(3'd4, d); chk("R11 data word upper half", 64'(d), 64'h1234);

    // R12 / R2 / R5 / R6: every PHY address, write then read back
    for (int p = 0; p < 32; p++) begin
      logic [4:0] pa = 5'(p);
      logic [4:0] ra = pa ^ 5'h0A;
      logic [15:0] wv = {pa, 3'b101, ~pa, 3'b011};
      run_cmd(1'b0, pa, ra, wv, "R5 R12 write");
      if (p == 0) chk("R10 mdc period", 64'(t2 - t1), 64'(2 * HALF));
      run_cmd(1'b1, pa, ra, 16'h0, present(pa) ? "R12 read back" : "R6 absent read");
    end

    // R4 register sweep on one present PHY
    for (int r = 0; r < 32; r++) run_cmd(1'b1, 5'd5, 5'(r), 16'h0, "R4 reg sweep");

    // R7 command during a busy frame is dropped
    rises = 0;
    bus_wr(3'd0, cmd(1'b0, 1'b1, 5'd9, 5'd2));
    bus_wr(3'd0, cmd(1'b1, 1'b0, 5'd4, 5'd7));
    wait_idle();
    bus_rd(3'd0, d);
    chk("R7 fields and result kept", 64'(d), 64'(cmd(1'b0, 1'b0, 5'd9, 5'd2) | {16'd0, mem[9][2]}));
    repeat (50) @(negedge clk);
    chk("R7 no extra frame", 64'(rises), 64'd64);
    chk("R1 mdc low when idle", 64'(mdc_o), 64'd0);

    // R8 both start bits: read wins
    rises = 0;
    bus_wr(3'd0, cmd(1'b1, 1'b1, 5'd6, 5'd3));
    bus_rd(3'd0, d);
    chk("R8 only read busy", 64'(d[27:26]), 64'd1);
    wait_idle();
    chk("R8 opcode is read", 64'(cap[29:28]), 64'd2);
    bus_rd(3'd0, d);
    chk("R8 read result", 64'(d[15:0]), 64'(mem[6][3]));

    chk("R9 mdio stable while mdc high", 64'(bad9), 64'd0);
    finish_run();
  end
endmodule